// File: doc/BRIEF.md
# Data Cache Line Coherency Tracker

This block holds a four-state coherency code for every line of a small direct-indexed L1 data cache. Each clock it takes at most one event. An event carries an event code, a line index, three page attribute bits (write-through, cache-inhibited, coherence-required) and the bus shared indication that goes with a fill. The block reads the current code of the indexed line and works out the next code from the event and the attribute bits. It writes that code back and, one cycle later, reports both the old and the new code.

The transition rules depend on the attribute bits as well as the event. Write-through stores, cache-inhibited accesses and non-coherent fills therefore each follow their own path rather than plain MESI. Any event whose attribute bits fit none of its rules leaves the line untouched and raises a one-cycle unmatched flag. Cache-management events do not change a line. They only request an address broadcast, and only while the broadcast enable input is high. Tag compare, data storage and the bus protocol belong to neighbouring blocks.

Top module: `coh_tracker`

## Requirements
- R1: After reset every line holds Invalid. The state encoding on `old_st` and `new_st` is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: A load (code 1), or a load-reserve (code 3) with write-through=0, that has inhibited=0 and finds the line Invalid fills it. The fill is Shared when `bus_shared`=1 and coherence-required=1, and Exclusive otherwise. If such an event finds the line Shared, Exclusive or Modified, the line keeps its state.
- R3: A load (1), store (2) or load-reserve (3) with inhibited=1 leaves the line state unchanged.
- R4: A store (2), store-conditional (4) or zero-line (5) with write-through=0 and inhibited=0 moves the line to Modified from any state.
- R5: A store (2) with write-through=1 and inhibited=0 keeps a Modified or Exclusive line as it is, and moves a Shared or Invalid line to Invalid.
- R6: Touch (6) or touch-and-lock (7) aimed at the outer cache level moves the line to Invalid when inhibited=0. Touch-for-store-and-lock (8) aimed at the outer level does the same when write-through=0 and inhibited=0.
- R7: Management events leave the line state unchanged. These are lock-clear aimed at the outer level (9), store-back (10), flush (11), invalidate (12), barrier (13), sync (14) and instruction-block invalidate (15). `bcast_req` is high in the report cycle exactly when such an event arrived with `bcast_en`=1. All other events leave `bcast_req` low.
- R8: An event whose attribute bits match none of its rules leaves the line unchanged and sets `unmatched` for its report cycle only. These are load-reserve with write-through=1 and inhibited=0; codes 4, 5 and 8 unless write-through=0 and inhibited=0; and codes 6 and 7 with inhibited=1.
- R9: Code 0 is idle: no line changes and `rep_vld` stays low in the following cycle. Any other code gives `rep_vld`=1 with the old and new state in the next cycle. An event on the same line in the next cycle sees the state just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_code | input | 4 | Event code, 0 = idle |
| ev_idx | input | IDX_W | Line index of the event |
| attr_wt | input | 1 | Page is write-through |
| attr_ci | input | 1 | Page is cache-inhibited |
| attr_mc | input | 1 | Page requires coherence |
| bus_shared | input | 1 | Another cache holds the line (fills) |
| bcast_en | input | 1 | Address-broadcast enable |
| rep_vld | output | 1 | Report of the previous cycle's event is valid |
| old_st | output | 2 | State of the line before the event |
| new_st | output | 2 | State of the line after the event |
| unmatched | output | 1 | Previous event matched no rule |
| bcast_req | output | 1 | Broadcast request for a management event |

## Verification
A wrong stored code stays hidden until that line is touched again. It then shows on `old_st` in the report cycle of that later event and usually also bends `new_st`. A wrong transition appears at once in `new_st` one cycle after the event. The reference model therefore confines much of the random traffic to a few lines, so that a corrupted line is revisited within a few cycles. It also issues back-to-back events to the same index to expose stale reads.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } line_st_e;

  typedef enum logic [3:0] {
    EV_IDLE    = 4'd0,
    EV_LOAD    = 4'd1,
    EV_STORE   = 4'd2,
    EV_LDRSV   = 4'd3,
    EV_STCOND  = 4'd4,
    EV_ZERO    = 4'd5,
    EV_TOUCH   = 4'd6,
    EV_TLOCK   = 4'd7,
    EV_TSLOCK  = 4'd8,
    EV_LCLR    = 4'd9,
    EV_STBACK  = 4'd10,
    EV_FLUSH   = 4'd11,
    EV_INVAL   = 4'd12,
    EV_BARRIER = 4'd13,
    EV_SYNC    = 4'd14,
    EV_IBINV   = 4'd15
  } ev_e;

  localparam ev_e FIRST_MGMT = EV_LCLR;

endpackage

// File: rtl/coh_state_array.sv
module coh_state_array
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  line_st_e         wr_st,
  output line_st_e         rd_st
);

  line_st_e mem [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit;
    assign hit = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= ST_INV;
      end else if (hit) begin
        mem[g] <= wr_st;
      end
    end
  end

  assign rd_st = mem[idx];

endmodule

// File: rtl/coh_next_state.sv
module coh_next_state
  import coh_pkg::*;
(
  input  ev_e      code,
  input  line_st_e cur,
  input  logic     wt,
  input  logic     ci,
  input  logic     mc,
  input  logic     shared,
  output line_st_e nxt,
  output logic     unm
);

  line_st_e fill;
  logic     cacheable_wb;

  assign fill         = (mc && shared) ? ST_SHR : ST_EXC;
  assign cacheable_wb = !wt && !ci;

  always_comb begin
    nxt = cur;
    unm = 1'b0;
    case (code)
      EV_LOAD: begin
        if (!ci && cur == ST_INV) nxt = fill;
      end
      EV_LDRSV: begin
        if (!ci) begin
          if (!wt) begin
            if (cur == ST_INV) nxt = fill;
          end else begin
            unm = 1'b1;
          end
        end
      end
      EV_STORE: begin
        if (!ci) begin
          if (!wt)                                   nxt = ST_MOD;
          else if (cur == ST_SHR || cur == ST_INV)   nxt = ST_INV;
        end
      end
      EV_STCOND, EV_ZERO: begin
        if (cacheable_wb) nxt = ST_MOD;
        else              unm = 1'b1;
      end
      EV_TOUCH, EV_TLOCK: begin
        if (!ci) nxt = ST_INV;
        else     unm = 1'b1;
      end
      EV_TSLOCK: begin
        if (cacheable_wb) nxt = ST_INV;
        else              unm = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/coh_bcast.sv
module coh_bcast
  import coh_pkg::*;
(
  input  ev_e  code,
  input  logic enable,
  output logic req
);

  logic is_mgmt;

  assign is_mgmt = (code >= FIRST_MGMT);
  assign req     = is_mgmt && enable;

endmodule

// File: rtl/coh_tracker.sv
module coh_tracker
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ev_code,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             attr_wt,
  input  logic             attr_ci,
  input  logic             attr_mc,
  input  logic             bus_shared,
  input  logic             bcast_en,
  output logic             rep_vld,
  output logic [1:0]       old_st,
  output logic [1:0]       new_st,
  output logic             unmatched,
  output logic             bcast_req
);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m   <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m   <= 1'b1;
      rst_s_n <= rst_m;
    end
  end

  ev_e      code;
  line_st_e cur_st, nxt_st;
  logic     nxt_unm, nxt_bc, ev_act;

  assign code   = ev_e'(ev_code);
  assign ev_act = (code != EV_IDLE);

  coh_state_array #(.LINES(LINES)) i_array (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (ev_act),
    .idx   (ev_idx),
    .wr_st (nxt_st),
    .rd_st (cur_st)
  );

  coh_next_state i_next (
    .code   (code),
    .cur    (cur_st),
    .wt     (attr_wt),
    .ci     (attr_ci),
    .mc     (attr_mc),
    .shared (bus_shared),
    .nxt    (nxt_st),
    .unm    (nxt_unm)
  );

  coh_bcast i_bcast (
    .code   (code),
    .enable (bcast_en),
    .req    (nxt_bc)
  );

  // report register: next-state and flop processes kept apart
  logic     rep_vld_d, unm_d, bc_d;
  line_st_e old_d, new_d;
  line_st_e old_q, new_q;

  always_comb begin
    rep_vld_d = ev_act;
    old_d     = ev_act ? cur_st : old_q;
    new_d     = ev_act ? nxt_st : new_q;
    unm_d     = ev_act && nxt_unm;
    bc_d      = ev_act && nxt_bc;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rep_vld   <= 1'b0;
      old_q     <= ST_INV;
      new_q     <= ST_INV;
      unmatched <= 1'b0;
      bcast_req <= 1'b0;
    end else begin
      rep_vld   <= rep_vld_d;
      old_q     <= old_d;
      new_q     <= new_d;
      unmatched <= unm_d;
      bcast_req <= bc_d;
    end
  end

  assign old_st = old_q;
  assign new_st = new_q;

  AST_FILL_PICK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_code == 4'd1 && !attr_ci) |=>
      (old_st != 2'b00 || new_st == (($past(attr_mc) && $past(bus_shared)) ? 2'b01 : 2'b10))); // R2
  AST_CI_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((ev_code == 4'd1 || ev_code == 4'd2 || ev_code == 4'd3) && attr_ci) |=> (new_st == old_st)); // R3
  AST_STORE_MOD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_code == 4'd2 && !attr_wt && !attr_ci) |=> (new_st == 2'b11)); // R4
  AST_WT_STORE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_code == 4'd2 && attr_wt && !attr_ci) |=> (new_st == old_st || new_st == 2'b00)); // R5
  AST_BCAST_GATE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_code >= 4'd9) |=> (bcast_req == $past(bcast_en) && new_st == old_st)); // R7
  AST_UNM_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    unmatched |-> (rep_vld && new_st == old_st)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_code == 4'd0) |=> (!rep_vld && !unmatched && !bcast_req)); // R9

endmodule

// File: tb/test_coh_tracker.sv
module test_coh_tracker;

  localparam int LINES = 16;
  localparam int IW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    ev_code;
  logic [IW-1:0] ev_idx;
  logic          attr_wt, attr_ci, attr_mc, bus_shared, bcast_en;
  logic          rep_vld, unmatched, bcast_req;
  logic [1:0]    old_st, new_st;

  always #2.5 clk = ~clk;

  coh_tracker #(.LINES(LINES)) i_coh_tracker (
    .clk(clk), .rst_n(rst_n), .ev_code(ev_code), .ev_idx(ev_idx),
    .attr_wt(attr_wt), .attr_ci(attr_ci), .attr_mc(attr_mc),
    .bus_shared(bus_shared), .bcast_en(bcast_en),
    .rep_vld(rep_vld), .old_st(old_st), .new_st(new_st),
    .unmatched(unmatched), .bcast_req(bcast_req)
  );

  int    total = 0, bad = 0;
  bit    done = 0;
  int    mdl [LINES];
  int    e_vld = 0, e_old = 0, e_new = 0, e_unm = 0, e_bc = 0;
  string e_tag = "R9";
  int unsigned seed = 32'h1234_5678;

  // behavioural reference for one event
  task automatic model(input int c, input int ix, input int wt, input int ci,
                       input int mc, input int sh, input int be, input string forced);
    int o, n, u;
    string t;
    o = mdl[ix]; n = o; u = 0; t = "R9";
    if (c == 1 || c == 3) begin
      if (ci) t = "R3";
      else if (c == 3 && wt) begin u = 1; t = "R8"; end
      else begin t = "R2"; if (o == 0) n = (mc && sh) ? 1 : 2; end
    end else if (c == 2) begin
      if (ci) t = "R3";
      else if (!wt) begin t = "R4"; n = 3; end
      else begin t = "R5"; n = (o >= 2) ? o : 0; end
    end else if (c == 4 || c == 5) begin
      if (!wt && !ci) begin t = "R4"; n = 3; end else begin u = 1; t = "R8"; end
    end else if (c == 6 || c == 7) begin
      if (!ci) begin t = "R6"; n = 0; end else begin u = 1; t = "R8"; end
    end else if (c == 8) begin
      if (!wt && !ci) begin t = "R6"; n = 0; end else begin u = 1; t = "R8"; end
    end else if (c >= 9) begin
      t = "R7";
    end
    if (forced != "") t = forced;
    if (c != 0) mdl[ix] = n;
    e_vld = (c != 0);
    e_old = o; e_new = n; e_unm = u;
    e_bc  = (c >= 9 && be) ? 1 : 0;
    e_tag = t;
  endtask

  task automatic check_now();
    total++;
    if (rep_vld !== e_vld[0] ||
        (e_vld != 0 && (old_st !== e_old[1:0] || new_st !== e_new[1:0] ||
                        unmatched !== e_unm[0] || bcast_req !== e_bc[0]))) begin
      bad++;
      $display("FAIL %s: got vld=%0d old=%0d new=%0d unm=%0d bc=%0d exp vld=%0d old=%0d new=%0d unm=%0d bc=%0d",
               e_tag, rep_vld, old_st, new_st, unmatched, bcast_req,
               e_vld, e_old, e_new, e_unm, e_bc);
    end
  endtask

  task automatic step(input int c, input int ix, input int wt, input int ci,
                      input int mc, input int sh, input int be, input string forced = "");
    @(negedge clk);
    check_now();
    model(c, ix, wt, ci, mc, sh, be, forced);
    ev_code = 4'(c); ev_idx = IW'(ix);
    attr_wt = wt[0]; attr_ci = ci[0]; attr_mc = mc[0];
    bus_shared = sh[0]; bcast_en = be[0];
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % m);
  endfunction

  initial begin
    for (int i = 0; i < LINES; i++) mdl[i] = 0;
    rst_n = 1'b0;
    ev_code = 4'd0; ev_idx = '0; attr_wt = 0; attr_ci = 0; attr_mc = 0;
    bus_shared = 0; bcast_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet while reset release settles
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, "R1");
    // R1: every line reads Invalid (inhibited load leaves it as is)
    for (int i = 0; i < LINES; i++) step(1, i, 0, 1, 1, 0, 0, "R1");
    // R2: fills, shared / exclusive / non-coherent
    step(1, 0, 0, 0, 1, 1, 0);
    step(1, 1, 0, 0, 1, 0, 0);
    step(1, 2, 0, 0, 0, 1, 0);
    step(3, 3, 0, 0, 1, 1, 0);
    step(1, 0, 0, 0, 1, 0, 0);
    // R4 / R5
    step(2, 0, 1, 0, 1, 0, 0);
    step(2, 1, 1, 0, 1, 0, 0);
    step(2, 4, 0, 0, 1, 0, 0);
    step(2, 4, 1, 0, 1, 0, 0);
    step(5, 5, 0, 0, 0, 0, 0);
    step(4, 6, 0, 0, 1, 0, 0);
    // R6
    step(6, 4, 0, 0, 1, 0, 0);
    step(8, 5, 0, 0, 1, 0, 0);
    step(7, 6, 1, 0, 1, 0, 0);
    // R8
    step(4, 7, 1, 0, 1, 0, 0);
    step(3, 7, 1, 0, 1, 0, 0);
    step(6, 7, 0, 1, 1, 0, 0);
    // R7 both enable values
    step(12, 0, 0, 0, 1, 0, 1);
    step(11, 0, 0, 0, 1, 0, 0);
    step(9, 1, 0, 0, 1, 0, 1);
    // R9 idle gap then same-line back-to-back
    step(0, 3, 0, 0, 1, 0, 1);
    step(5, 8, 0, 0, 1, 0, 0);
    step(2, 8, 1, 0, 1, 0, 0);
    step(6, 8, 0, 0, 1, 0, 0);
    // random traffic, mostly on a few lines
    for (int k = 0; k < 6000; k++) begin
      int ix;
      ix = (rnd(4) == 0) ? rnd(LINES) : rnd(3);
      step(rnd(16), ix, rnd(2), (rnd(4) == 0) ? 1 : 0, rnd(2), rnd(2), rnd(2));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_now();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule